// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Controller

A small accumulator core whose control is a fixed state machine rather than a stored microprogram. Every instruction goes through a fetch cycle and then an execute cycle. An indirect cycle is placed between them only when the instruction word asks for indirect addressing. An interrupt cycle follows execute only when a request is present and interrupts are enabled. Each cycle has exactly three timing steps. In each step one group of register transfers among the program counter, memory address register, memory buffer register, instruction register and accumulator R1 completes on the clock edge.

The core drives a single-port synchronous memory that has one clock of read latency. The address bus carries the value the address register takes at the end of the current step, so the memory captures the address at that edge and presents the word in the next step. An instruction word is 16 bits: a 3-bit opcode in bits 15:13, an indirect flag in bit 12 and a 12-bit address field in bits 11:0. The opcodes are 0 load R1, 1 store R1, 2 add to R1, 3 jump, 4 enable interrupts and 7 halt. Opcodes 5 and 6 do nothing.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While reset is held, the core is in fetch step 1 (`cycle_o`=0, `step_o`=0), PC=0, R1=0, `halted_o`=0, `mem_we_o`=0, and interrupts are disabled.
- R2: Fetch drives PC on the address bus in step 1. PC becomes PC+1 at the end of step 2. The word read becomes the instruction at the end of step 3.
- R3: When bit 12 of the fetched word is 1, an indirect cycle (`cycle_o`=1) follows fetch. Its step 1 puts the address field on the bus, and the address field is then replaced by bits 11:0 of the word read from memory.
- R4: Load (0) and add (2) put the effective address on the bus in execute step 1. R1 takes the memory word, or R1 plus the word modulo 2^16, at the end of execute step 3.
- R5: Store (1) asserts `mem_we_o` only in execute step 3, with the effective address on the bus and R1 on `mem_wdata_o`.
- R6: Jump (3) loads PC with the effective address at the end of execute step 1.
- R7: If `irq_i` is high and interrupts are enabled at execute step 3, an interrupt cycle (`cycle_o`=3) follows. It disables interrupts, sets PC to `ISR_ADDR` at the end of its step 2 and writes the old PC to `SAVE_ADDR` in its step 3.
- R8: While interrupts are disabled, a high `irq_i` has no effect, and fetch follows execute.
- R9: Enable-interrupts (4) turns interrupts on at the end of execute step 1.
- R10: Halt (7) sets `halted_o` at the end of execute step 1. From then on the state, PC, R1 and bus outputs stay frozen and no write occurs.
- R11: Steps run 1, 2, 3 (`step_o` 0, 1, 2). The cycle type changes only after step 3, in the order fetch, optional indirect, execute, optional interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request level |
| mem_rdata_i | input | 16 | Memory read data, valid one step after its address |
| mem_addr_o | output | 12 | Memory address |
| mem_wdata_o | output | 16 | Memory write data (buffer register) |
| mem_we_o | output | 1 | Memory write strobe |
| pc_o | output | 12 | Program counter |
| r1_o | output | 16 | Accumulator R1 |
| cycle_o | output | 2 | Cycle type: 0 fetch, 1 indirect, 2 execute, 3 interrupt |
| step_o | output | 2 | Timing step 0..2 |
| halted_o | output | 1 | Core has executed halt |

## Verification
A wrong step or cycle register shows on `cycle_o`/`step_o` in the same clock, and the address bus shifts as well, because it follows the next address register value. A lost PC increment or a misrouted buffer register shows up as the wrong fetch address three to nine clocks later, or as the wrong accumulator value at the end of the next load or add. A faulty interrupt-enable flag appears as an interrupt cycle where fetch was expected, or the reverse, at the first execute step 3 that samples a request. Comparing every port against an instruction-level model on every clock catches each of these within one instruction.

// File: rtl/ic_pkg.sv
`timescale 1ns/1ps
package ic_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_INDIR = 2'd1,
    CYC_EXEC  = 2'd2,
    CYC_IRQ   = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    ST_T1 = 2'd0,
    ST_T2 = 2'd1,
    ST_T3 = 2'd2
  } step_e;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_ADD   = 3'd2;
  localparam logic [2:0] OP_JUMP  = 3'd3;
  localparam logic [2:0] OP_EI    = 3'd4;
  localparam logic [2:0] OP_HALT  = 3'd7;
endpackage

// File: rtl/ic_sequencer.sv
`timescale 1ns/1ps
module ic_sequencer
  import ic_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ind_i,
  input  logic  irq_take_i,
  input  logic  halt_i,
  output cyc_e  cyc_o,
  output step_e step_o,
  output logic  halted_o
);
  cyc_e  cyc_q, cyc_nxt;
  step_e step_q;
  logic  halted_q;

  always_comb begin
    unique case (cyc_q)
      CYC_FETCH: cyc_nxt = ind_i ? CYC_INDIR : CYC_EXEC;
      CYC_INDIR: cyc_nxt = CYC_EXEC;
      CYC_EXEC:  cyc_nxt = irq_take_i ? CYC_IRQ : CYC_FETCH;
      default:   cyc_nxt = CYC_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q    <= CYC_FETCH;
      step_q   <= ST_T1;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (halt_i) begin
        halted_q <= 1'b1;
      end else begin
        unique case (step_q)
          ST_T1:   step_q <= ST_T2;
          ST_T2:   step_q <= ST_T3;
          default: begin
            step_q <= ST_T1;
            cyc_q  <= cyc_nxt;
          end
        endcase
      end
    end
  end

  assign cyc_o    = cyc_q;
  assign step_o   = step_q;
  assign halted_o = halted_q;

  assert_step_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q != 2'd3);
  assert_step_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_q && step_q == ST_T3) |=> step_q == ST_T1);
  assert_cycle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != ST_T3) |=> $stable(cyc_q));
  assert_halt_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (halted_q && $stable(step_q) && $stable(cyc_q)));
endmodule

// File: rtl/ic_datapath.sv
`timescale 1ns/1ps
module ic_datapath
  import ic_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned OP_W      = 3,
  parameter int unsigned SAVE_ADDR = 0,
  parameter int unsigned ISR_ADDR  = 1,
  localparam int unsigned DW       = OP_W + 1 + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_e              cyc_i,
  input  step_e             step_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DW-1:0]     r1_o,
  output logic              ie_o,
  output logic [2:0]        op_o,
  output logic              mbr_ind_o
);
  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] ISR_A  = ADDR_W'(ISR_ADDR);

  logic [ADDR_W-1:0] pc_q, mar_q, mar_d, ea;
  logic [DW-1:0]     mbr_q, ir_q, r1_q;
  logic              ie_q;
  logic [2:0]        op;
  logic              mem_op;

  assign op     = 3'(ir_q[DW-1 -: OP_W]);
  assign ea     = ir_q[ADDR_W-1:0];
  assign mem_op = (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD);

  // next address register value drives the bus so memory samples it this edge
  always_comb begin
    mar_d = mar_q;
    unique case (cyc_i)
      CYC_FETCH: if (step_i == ST_T1) mar_d = pc_q;
      CYC_INDIR: if (step_i == ST_T1) mar_d = ea;
      CYC_EXEC:  if (step_i == ST_T1 && mem_op) mar_d = ea;
      default:   if (step_i == ST_T2) mar_d = SAVE_A;
    endcase
  end

  assign mem_we_o = (step_i == ST_T3) &&
                    ((cyc_i == CYC_EXEC && op == OP_STORE) || cyc_i == CYC_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      r1_q  <= '0;
      ie_q  <= 1'b0;
    end else begin
      mar_q <= mar_d;
      unique case (cyc_i)
        CYC_FETCH: begin
          if (step_i == ST_T2) begin
            mbr_q <= mem_rdata_i;
            pc_q  <= pc_q + 1'b1;
          end
          if (step_i == ST_T3) ir_q <= mbr_q;
        end
        CYC_INDIR: begin
          if (step_i == ST_T2) mbr_q <= mem_rdata_i;
          if (step_i == ST_T3) ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
        end
        CYC_EXEC: begin
          if (step_i == ST_T1 && op == OP_JUMP) pc_q <= ea;
          if (step_i == ST_T1 && op == OP_EI)   ie_q <= 1'b1;
          if (step_i == ST_T2) begin
            if (op == OP_STORE) mbr_q <= r1_q;
            else if (op == OP_LOAD || op == OP_ADD) mbr_q <= mem_rdata_i;
          end
          if (step_i == ST_T3) begin
            if (op == OP_LOAD)     r1_q <= mbr_q;
            else if (op == OP_ADD) r1_q <= r1_q + mbr_q;
          end
        end
        default: begin
          if (step_i == ST_T1) begin
            mbr_q <= DW'(pc_q);
            ie_q  <= 1'b0;
          end
          if (step_i == ST_T2) pc_q <= ISR_A;
        end
      endcase
    end
  end

  assign mem_addr_o  = mar_d;
  assign mem_wdata_o = mbr_q;
  assign pc_o        = pc_q;
  assign r1_o        = r1_q;
  assign ie_o        = ie_q;
  assign op_o        = op;
  assign mbr_ind_o   = mbr_q[ADDR_W];

  assert_write_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (step_i == ST_T3 && (cyc_i == CYC_EXEC || cyc_i == CYC_IRQ)));
  assert_pc_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_FETCH && step_i == ST_T2) |=> pc_q == $past(pc_q) + 1'b1);
  assert_irq_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_IRQ && step_i == ST_T1) |=> !ie_q);
  assert_irq_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_IRQ && step_i == ST_T3) |-> (pc_q == ISR_A && mem_addr_o == SAVE_A));
  assert_r1_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_i == CYC_EXEC && step_i == ST_T3) |=> $stable(r1_q));
endmodule

// File: rtl/instr_cycle_ctrl.sv
`timescale 1ns/1ps
module instr_cycle_ctrl
  import ic_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned OP_W      = 3,
  parameter int unsigned SAVE_ADDR = 0,
  parameter int unsigned ISR_ADDR  = 1,
  localparam int unsigned DW       = OP_W + 1 + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DW-1:0]     r1_o,
  output logic [1:0]        cycle_o,
  output logic [1:0]        step_o,
  output logic              halted_o
);
  cyc_e       cyc;
  step_e      step;
  logic       ie, mbr_ind, halted, halt_req;
  logic [2:0] op;

  assign halt_req = (cyc == CYC_EXEC) && (step == ST_T1) && (op == OP_HALT);

  ic_sequencer u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ind_i      (mbr_ind),
    .irq_take_i (irq_i & ie),
    .halt_i     (halt_req),
    .cyc_o      (cyc),
    .step_o     (step),
    .halted_o   (halted)
  );

  ic_datapath #(
    .ADDR_W    (ADDR_W),
    .OP_W      (OP_W),
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_i       (cyc),
    .step_i      (step),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .pc_o        (pc_o),
    .r1_o        (r1_o),
    .ie_o        (ie),
    .op_o        (op),
    .mbr_ind_o   (mbr_ind)
  );

  assign cycle_o  = cyc;
  assign step_o   = step;
  assign halted_o = halted;

  assert_halted_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted |-> !mem_we_o);
  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == CYC_EXEC && step == ST_T3 && !ie) |=> cyc == CYC_FETCH);
endmodule

// File: tb/instr_cycle_ctrl_test.sv
`timescale 1ns/1ps
module instr_cycle_ctrl_test;
  localparam int SAVE = 'h60;
  localparam int ISR  = 'h70;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_i = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [11:0] pc;
  logic [15:0] r1;
  logic [1:0]  cyc, stp;
  logic        halted;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  instr_cycle_ctrl #(.SAVE_ADDR(SAVE), .ISR_ADDR(ISR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i), .mem_rdata_i(mem_rdata),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .pc_o(pc), .r1_o(r1), .cycle_o(cyc), .step_o(stp), .halted_o(halted)
  );

  logic [15:0] bmem [256];
  logic [15:0] mmem [256];

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= bmem[mem_addr[7:0]];
  end

  typedef struct {
    int cyc; int stp; int pc; int r1; int we; int addr; int wd; int hlt; string tag;
  } exp_t;
  exp_t q[$];
  int m_pc, m_r1, m_mar, m_ie;

  function automatic bit irq_at(int k);
    return (k >= 3 && k < 20) || (k >= 50 && k < 56) || (k >= 84 && k < 88);
  endfunction

  function automatic logic [15:0] enc(int op, int ind, int a);
    return {3'(op), 1'(ind), 12'(a)};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(int c, int s, int we, int wd, int h, string tag);
    exp_t e;
    e.cyc = c; e.stp = s; e.pc = m_pc; e.r1 = m_r1; e.we = we;
    e.addr = m_mar; e.wd = wd; e.hlt = h; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic build_model();
    bit done = 0;
    bit masked = 0;
    m_pc = 0; m_r1 = 0; m_mar = 0; m_ie = 0;
    while (!done && q.size() < 1000) begin
      int ir, op, ea, saved;
      string ft;
      ft = masked ? "R8" : "R2";
      masked = 0;
      m_mar = m_pc;
      push(0, 0, 0, 0, 0, ft);
      push(0, 1, 0, 0, 0, "R2");
      m_pc = (m_pc + 1) & 'hfff;
      push(0, 2, 0, 0, 0, "R2");
      ir = int'(mmem[m_mar & 'hff]);
      op = (ir >> 13) & 7;
      ea = ir & 'hfff;
      if (((ir >> 12) & 1) == 1) begin
        m_mar = ea;
        push(1, 0, 0, 0, 0, "R3");
        push(1, 1, 0, 0, 0, "R3");
        push(1, 2, 0, 0, 0, "R3");
        ea = int'(mmem[ea & 'hff]) & 'hfff;
      end
      case (op)
        0, 2: begin
          m_mar = ea;
          push(2, 0, 0, 0, 0, "R4");
          push(2, 1, 0, 0, 0, "R4");
          push(2, 2, 0, 0, 0, "R4");
          if (op == 0) m_r1 = int'(mmem[ea & 'hff]);
          else m_r1 = (m_r1 + int'(mmem[ea & 'hff])) & 'hffff;
        end
        1: begin
          m_mar = ea;
          push(2, 0, 0, 0, 0, "R5");
          push(2, 1, 0, 0, 0, "R5");
          push(2, 2, 1, m_r1, 0, "R5");
          mmem[ea & 'hff] = 16'(m_r1);
        end
        3: begin
          push(2, 0, 0, 0, 0, "R6");
          m_pc = ea;
          push(2, 1, 0, 0, 0, "R6");
          push(2, 2, 0, 0, 0, "R6");
        end
        4: begin
          push(2, 0, 0, 0, 0, "R9");
          m_ie = 1;
          push(2, 1, 0, 0, 0, "R9");
          push(2, 2, 0, 0, 0, "R9");
        end
        7: begin
          push(2, 0, 0, 0, 0, "R10");
          for (int i = 0; i < 12; i++) push(2, 0, 0, 0, 1, "R10");
          done = 1;
        end
        default: begin
          push(2, 0, 0, 0, 0, "R11");
          push(2, 1, 0, 0, 0, "R11");
          push(2, 2, 0, 0, 0, "R11");
        end
      endcase
      if (!done && irq_at(q.size() - 1)) begin
        if (m_ie == 1) begin
          saved = m_pc;
          push(3, 0, 0, 0, 0, "R7");
          m_ie = 0;
          m_mar = SAVE;
          push(3, 1, 0, 0, 0, "R7");
          m_pc = ISR;
          push(3, 2, 1, saved, 0, "R7");
          mmem[SAVE] = 16'(saved);
        end else begin
          masked = 1;
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 16'h0;
    bmem['h00] = enc(0, 0, 'h40);
    bmem['h01] = enc(2, 0, 'h41);
    bmem['h02] = enc(2, 1, 'h42);
    bmem['h03] = enc(1, 0, 'h50);
    bmem['h04] = enc(4, 0, 0);
    bmem['h05] = enc(0, 1, 'h44);
    bmem['h06] = enc(3, 0, 'h08);
    bmem['h07] = enc(7, 0, 0);
    bmem['h08] = enc(2, 0, 'h50);
    bmem['h09] = enc(3, 1, 'h45);
    bmem['h0A] = enc(7, 0, 0);
    bmem['h0B] = enc(1, 0, 'h51);
    bmem['h0C] = enc(7, 0, 0);
    bmem['h40] = 16'd5;
    bmem['h41] = 16'd7;
    bmem['h42] = 16'h0043;
    bmem['h43] = 16'hFFFF;
    bmem['h44] = 16'h0050;
    bmem['h45] = 16'h000B;
    bmem['h70] = enc(2, 0, 'h41);
    bmem['h71] = enc(4, 0, 0);
    bmem['h72] = enc(3, 1, SAVE);
    for (int i = 0; i < 256; i++) mmem[i] = bmem[i];
    build_model();

    repeat (2) @(negedge clk);
    chk("R1", "cycle", int'(cyc), 0);
    chk("R1", "step", int'(stp), 0);
    chk("R1", "pc", int'(pc), 0);
    chk("R1", "r1", int'(r1), 0);
    chk("R1", "halted", int'(halted), 0);
    chk("R1", "we", int'(mem_we), 0);
    rst_ni = 1'b1;

    for (int k = 0; k < q.size(); k++) begin
      irq_i = irq_at(k);
      #1;
      chk(q[k].tag, "cycle", int'(cyc), q[k].cyc);
      chk("R11", "step", int'(stp), q[k].stp);
      chk(q[k].tag, "pc", int'(pc), q[k].pc);
      chk(q[k].tag, "r1", int'(r1), q[k].r1);
      chk(q[k].tag, "addr", int'(mem_addr), q[k].addr);
      chk(q[k].tag, "we", int'(mem_we), q[k].we);
      chk(q[k].tag, "halted", int'(halted), q[k].hlt);
      if (q[k].we == 1) chk(q[k].tag, "wdata", int'(mem_wdata), q[k].wd);
      @(posedge clk);
      @(negedge clk);
    end

    chk("R4", "mem[50] wrap sum", int'(bmem['h50]), 11);
    chk("R5", "mem[51]", int'(bmem['h51]), int'(mmem['h51]));
    chk("R7", "mem[save]", int'(bmem[SAVE]), int'(mmem[SAVE]));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule